// File: doc/BRIEF.md
# Radix-2 Recoded Signed Array Multiplier

This block multiplies two two's-complement operands of `N` bits each and gives the full `2N`-bit signed product. It has no clock. It is built as a triangular array of `N` rows of controlled add/subtract/transfer cells. Each row looks at one multiplier bit and at the bit just below it. From that pair the row decides whether to add the sign-extended multiplicand to the running partial product, subtract it, or pass the partial product on untouched. Negative operands need no correction step at the end.

The rows work from the most significant multiplier bit down to bit 0. Before each row after the first, the partial product is shifted left by one place. A new least significant cell with a zero partial-product input fills the gap, so every row is one bit wider than the row above it. The multiplicand is sign-extended to each row's width.

Every cell has two controls. The operate control selects arithmetic or plain transfer. The direction control selects add (carry chain) or subtract (borrow chain). The cell's sum output is the partial-product bit XORed with the gated multiplicand bit and the gated incoming carry. Its outgoing carry or borrow is `((p ^ d) & (a | c)) | (a & c)`.

Top module: `booth_cass_mult`

## Requirements
- R1: For every pair of `N`-bit signed operands, `prod_o` read as a signed `2N`-bit value equals the signed product of `mcand_i` and `mplier_i`.
- R2: The row for multiplier bit i reads the bit pair (bit i, bit i-1), where the bit below bit 0 is taken as 0. The pairs 00 and 11 pass the partial product through unchanged. The pair 01 adds the multiplicand and the pair 10 subtracts it. For example, multiplier 0110 gives +8·A − 2·A = 6·A.
- R3: The rows are weighted from the most significant multiplier bit down. A multiplier of 1000 (the most negative value) gives −2^(N−1)·A, and a multiplier of 0100 gives +2^(N−2)·A.
- R4: A zero multiplier gives a zero product for every multiplicand.
- R5: A zero multiplicand gives a zero product for every multiplier.
- R6: The most negative operand times itself gives +2^(2N−2) with no overflow (0x40 for N=4).
- R7: A multiplier of all ones (−1) gives the negated, sign-extended multiplicand.
- R8: A multiplier of 1 gives the multiplicand sign-extended to `2N` bits.
- R9: When both operands are nonzero, the product's most significant bit equals the XOR of the two operands' sign bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_i | input | N | Multiplicand, two's complement |
| mplier_i | input | N | Multiplier, two's complement |
| prod_o | output | 2N | Signed product |

## Verification
The checks assume that both operands are stable, fully defined two's-complement values, and they are evaluated only after the array has settled. The bench therefore changes the operands just after a clock edge and compares the product half a period later, so the deep ripple through the rows has finished before any comparison. The stimulus is every pair of 4-bit signed operands, followed by directed pairs for the zero, unit, minus-one and most-negative corners. Since every input value appears, no value outside the operand range can reach the array.

// File: rtl/booth_cass_pkg.sv
package booth_cass_pkg;

    // Row operation, encoded as {operate, direction}
    typedef enum logic [1:0] {
        OP_PASS = 2'b00,
        OP_ADD  = 2'b10,
        OP_SUB  = 2'b11
    } row_op_e;

    typedef struct packed {
        logic h;    // 1: operate, 0: transfer
        logic d;    // 1: subtract, 0: add
    } cass_ctrl_t;

    // Map (current bit, bit below) onto a row operation
    function automatic row_op_e recode_pair(input logic cur_bit, input logic low_bit);
        row_op_e op;
        case ({cur_bit, low_bit})
            2'b01:   op = OP_ADD;
            2'b10:   op = OP_SUB;
            default: op = OP_PASS;
        endcase
        return op;
    endfunction

    function automatic cass_ctrl_t op_to_ctrl(input row_op_e op);
        cass_ctrl_t c;
        c.h = op[1];
        c.d = op[0];
        return c;
    endfunction

    // Cell sum output
    function automatic logic cass_sum(input logic p, input logic a, input logic cin,
                                      input logic h);
        return p ^ (a & h) ^ (cin & h);
    endfunction

    // Cell carry (add) or borrow (subtract) output
    function automatic logic cass_carry(input logic p, input logic a, input logic cin,
                                        input logic d);
        return ((p ^ d) & (a | cin)) | (a & cin);
    endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_cass_pkg::*;
(
    input  logic       cur_bit,
    input  logic       low_bit,
    output cass_ctrl_t ctrl
);
    row_op_e op;

    always_comb begin
        op   = recode_pair(cur_bit, low_bit);
        ctrl = op_to_ctrl(op);
    end
endmodule

// File: rtl/cass_row.sv
module cass_row
    import booth_cass_pkg::*;
#(
    parameter int W = 5
) (
    input  cass_ctrl_t     ctrl,
    input  logic [W-1:0]   pin,
    input  logic [W-1:0]   a_ext,
    output logic [W-1:0]   pout
);
    // chain[k] is the carry/borrow entering cell k; none enters bit 0
    logic [W-1:0] chain;

    assign chain[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_cell
        assign pout[k] = cass_sum(pin[k], a_ext[k], chain[k], ctrl.h);
        if (k < W - 1) begin : g_link
            assign chain[k+1] = cass_carry(pin[k], a_ext[k], chain[k], ctrl.d);
        end
    end
endmodule

// File: rtl/booth_cass_mult.sv
module booth_cass_mult
    import booth_cass_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic [2*N-1:0] prod_o
);
    localparam int PW = 2 * N;

    // Multiplier with an implicit 0 below bit 0
    logic [N:0] mpl_ext;
    assign mpl_ext = {mplier_i, 1'b0};

    cass_ctrl_t row_ctrl [N];

    // Row r serves multiplier bit N-1-r (most significant first)
    for (genvar r = 0; r < N; r++) begin : g_row
        localparam int W  = N + 1 + r;
        localparam int BI = N - 1 - r;

        logic [W-1:0] pin;
        logic [W-1:0] a_ext;
        logic [W-1:0] pout;

        assign a_ext = {{(r + 1){mcand_i[N-1]}}, mcand_i};

        if (r == 0) begin : g_first
            assign pin = '0;
        end else begin : g_next
            assign pin = {g_row[r-1].pout, 1'b0};
        end

        booth_ctrl u_ctrl (
            .cur_bit (mpl_ext[BI+1]),
            .low_bit (mpl_ext[BI]),
            .ctrl    (row_ctrl[r])
        );

        cass_row #(.W(W)) u_row (
            .ctrl  (row_ctrl[r]),
            .pin   (pin),
            .a_ext (a_ext),
            .pout  (pout)
        );

        if (r == N - 1) begin : g_out
            assign prod_o = pout[PW-1:0];
        end
    end
endmodule

// File: rtl/booth_cass_mult_chk.sv
module booth_cass_mult_chk #(
    parameter int N = 4
) (
    input logic [N-1:0]   mcand_i,
    input logic [N-1:0]   mplier_i,
    input logic [2*N-1:0] prod_o
);
    localparam int PW = 2 * N;

    logic signed [PW-1:0] a_sx;
    logic signed [PW-1:0] x_sx;
    logic signed [PW-1:0] ref_p;

    always_comb begin
        a_sx  = {{N{mcand_i[N-1]}}, mcand_i};
        x_sx  = {{N{mplier_i[N-1]}}, mplier_i};
        ref_p = a_sx * x_sx;

        // R1
        product_match_chk: assert (prod_o == ref_p);
        // R4
        zero_mplier_chk: assert (mplier_i != '0 || prod_o == '0);
        // R5
        zero_mcand_chk: assert (mcand_i != '0 || prod_o == '0);
        // R7
        neg_one_chk: assert (mplier_i != '1 || prod_o == PW'(-a_sx));
        // R8
        unit_chk: assert (mplier_i != N'(1) || prod_o == a_sx);
        // R9
        sign_chk: assert (mcand_i == '0 || mplier_i == '0
                          || prod_o[PW-1] == (mcand_i[N-1] ^ mplier_i[N-1]));
    end
endmodule

bind booth_cass_mult booth_cass_mult_chk #(.N(N)) u_chk (.*);

// File: tb/booth_cass_mult_bench.sv
module booth_cass_mult_bench;
    localparam int N  = 4;
    localparam int PW = 2 * N;

    typedef struct {
        logic [N-1:0]  a;
        logic [N-1:0]  x;
        logic [PW-1:0] exp;
        bit            sign_only;
        string         tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0]  mcand;
    logic [N-1:0]  mplier;
    logic [PW-1:0] prod;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    item_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    booth_cass_mult #(.N(N)) u_booth_cass_mult (
        .mcand_i  (mcand),
        .mplier_i (mplier),
        .prod_o   (prod)
    );

    function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] x);
        logic signed [PW-1:0] sa;
        logic signed [PW-1:0] sx;
        sa = {{N{a[N-1]}}, a};
        sx = {{N{x[N-1]}}, x};
        return sa * sx;
    endfunction

    // Driver: apply an operand pair and queue the expected result
    task automatic drive(input logic [N-1:0] a, input logic [N-1:0] x,
                         input logic [PW-1:0] exp, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        mcand  = a;
        mplier = x;
        it.a = a; it.x = x; it.exp = exp; it.sign_only = 1'b0; it.tag = tag;
        sb_q.push_back(it);
        if (a != '0 && x != '0) begin
            // R9 sign rule
            it.sign_only = 1'b1;
            it.exp = {(a[N-1] ^ x[N-1]), {(PW-1){1'b0}}};
            it.tag = "R9";
            sb_q.push_back(it);
        end
    endtask

    // Monitor: compare mid-cycle, after the array has settled
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_tests++;
            if (it.sign_only) begin
                if (prod[PW-1] != it.exp[PW-1]) begin
                    n_fail++;
                    $display("FAIL %s a=%h x=%h sign actual=%b expected=%b",
                             it.tag, it.a, it.x, prod[PW-1], it.exp[PW-1]);
                end
            end else if (prod !== it.exp) begin
                n_fail++;
                $display("FAIL %s a=%h x=%h actual=%h expected=%h",
                         it.tag, it.a, it.x, prod, it.exp);
            end
        end
    end

    initial begin
        mcand  = '0;
        mplier = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R4: zero operands out of reset give zero
        drive('0, '0, '0, "R4");

        // R1: every signed operand pair
        for (int ia = 0; ia < (1 << N); ia++) begin
            for (int ix = 0; ix < (1 << N); ix++) begin
                drive(N'(ia), N'(ix), ref_mul(N'(ia), N'(ix)), "R1");
            end
        end

        // R2: pair recoding, 0110 -> +8A -2A = 6A
        drive(4'h3, 4'b0110, 8'h12, "R2");
        drive(4'hD, 4'b0110, 8'hEE, "R2");   // -3*6 = -18
        drive(4'h5, 4'b0101, 8'h19, "R2");   // alternating pairs, 25
        // R3: most significant row weighting
        drive(4'h3, 4'b1000, 8'hE8, "R3");   // 3*-8 = -24
        drive(4'h3, 4'b0100, 8'h0C, "R3");   // 3*4 = 12
        // R4 / R5: zero operand
        drive(4'h7, 4'h0, 8'h00, "R4");
        drive(4'h0, 4'h8, 8'h00, "R5");
        drive(4'h0, 4'hF, 8'h00, "R5");
        // R6: most negative squared
        drive(4'h8, 4'h8, 8'h40, "R6");
        // R7: times minus one
        drive(4'h5, 4'hF, 8'hFB, "R7");
        drive(4'h8, 4'hF, 8'h08, "R7");
        // R8: times one
        drive(4'hA, 4'h1, 8'hFA, "R8");
        drive(4'h7, 4'h1, 8'h07, "R8");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule